// File: doc/BRIEF.md
# Register Bank Averaging Engine

This block holds a small bank of unsigned sample registers and, on request, works out their arithmetic mean. Software or an upstream stage first fills the bank through a write stream. The stream has valid and ready signals and carries an address and a data word. A start level then launches the computation. The controller walks the bank one entry per clock, beginning at the highest index and ending at index 0. Each selected entry is added into a single accumulator. When the walk is finished, one further cycle divides the sum by the bank depth and registers the result.

The bank depth is a power of two of at least 2, so the division is a right shift that truncates toward zero. The accumulator is wide enough to hold the sum of a full bank of maximum values. The result is presented together with a completion flag. The flag stays high for as long as start is held. When start is released, the block goes back to idle and the bank can be written again.

Write stream rules: a word is stored when `wr_valid` and `wr_ready` are both high at a rising clock edge. `wr_ready` is high only while the block is idle, so a writer stalls for the whole of an operation. A word offered while `wr_ready` is low is neither stored nor queued.

Top module: `mean_calc`

## Requirements
- R1: After reset `done` is 0, `mean` is 0 and `wr_ready` is 1.
- R2: In idle, a write with `wr_valid` and `wr_ready` both high stores `wr_data` into the entry chosen by `wr_addr` (entry 0 to DEPTH-1), and the entry is used by the next operation.
- R3: `wr_ready` is 0 from the edge that samples `start` until the block is idle again; words offered in that time leave the bank unchanged.
- R4: An operation adds every one of the DEPTH entries exactly once, from index DEPTH-1 down to index 0, so entries at both ends of the bank count fully.
- R5: The sum is DATA_W + log2(DEPTH) bits wide and never wraps, so a bank full of all-ones values gives all-ones as the mean.
- R6: `mean` equals the sum of the entries shifted right by log2(DEPTH), with any remainder discarded.
- R7: Counting the rising edge that first samples `start` high as edge 1, `done` goes high after edge DEPTH+2, and `mean` is valid at that time.
- R8: `done` stays high while `start` stays high; one edge after `start` falls, `done` is 0 and `wr_ready` is 1.
- R9: `mean` changes only in the division step and keeps its value between operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Write stream word offered |
| wr_ready | output | 1 | Bank accepts writes (idle only) |
| wr_addr | input | log2(DEPTH) | Entry index of the offered word |
| wr_data | input | DATA_W | Unsigned sample to store |
| start | input | 1 | Level request to compute; hold until done is seen |
| mean | output | DATA_W | Truncated mean of the bank |
| done | output | 1 | Mean valid; held while start is high |

## Verification
The bench fills the bank with all-ones values. A design whose accumulator is too narrow would wrap the sum and report a small mean. It also loads odd sums, where a design that rounds up instead of truncating would be off by one. It places a single nonzero value at index 0, and then one at index DEPTH-1, to catch a walk that skips or repeats an end entry. It pushes a word while an operation is finishing and then reruns the same bank: a design that lets that write through would change the second result. Each operation also checks that `done` arrives exactly DEPTH+2 edges after start, stays up while start is held, and drops one edge after start is released.

// File: rtl/mean_pkg.sv
package mean_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_DIV  = 2'd2,
    ST_DONE = 2'd3
  } mc_state_t;
endpackage

// File: rtl/mean_regbank.sv
module mean_regbank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] entry_q [DEPTH];

  // One register per entry, each with its own address decode.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[g] <= '0;
      end else if (we && (waddr == AW'(g))) begin
        entry_q[g] <= wdata;
      end
    end
  end

  // Counter-driven read selector feeding the adder.
  assign rdata = entry_q[raddr];
endmodule

// File: rtl/mean_ctrl.sv
module mean_ctrl
  import mean_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] idx,
  output logic          clr,
  output logic          acc_en,
  output logic          ld_mean,
  output logic          idle,
  output logic          done
);
  mc_state_t state_q, state_d;
  logic [AW-1:0] idx_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_ACC;
      ST_ACC:  if (idx_q == '0) state_d = ST_DIV;
      ST_DIV:  state_d = ST_DONE;
      ST_DONE: if (!start) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Index preset to the top entry while idle, stepped down while adding.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= AW'(DEPTH - 1);
    end else if (state_q == ST_IDLE) begin
      idx_q <= AW'(DEPTH - 1);
    end else if (state_q == ST_ACC && idx_q != '0) begin
      idx_q <= idx_q - 1'b1;
    end
  end

  assign idx     = idx_q;
  assign clr     = (state_q == ST_IDLE);
  assign acc_en  = (state_q == ST_ACC);
  assign ld_mean = (state_q == ST_DIV);
  assign idle    = (state_q == ST_IDLE);
  assign done    = (state_q == ST_DONE);

  // R4: each adding step moves to the next lower entry.
  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACC && idx_q != '0) |=>
      (state_q == ST_ACC && idx_q == AW'($past(idx_q) - 1'b1)));

  // R6: the division step always directly follows the last addition.
  p_div_after_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DIV) |-> ($past(state_q) == ST_ACC && $past(idx_q) == '0));

  // R8: completion is held while start is held.
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> done);

  // R8: release of start returns to idle in one edge.
  p_done_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!done && idle));
endmodule

// File: rtl/mean_accum.sv
module mean_accum #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int SHIFT = $clog2(DEPTH),
  localparam int SUM_W = DATA_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_en,
  input  logic              ld_mean,
  input  logic [DATA_W-1:0] addend,
  output logic [DATA_W-1:0] mean
);
  logic [SUM_W-1:0]  sum_q;
  logic [DATA_W-1:0] mean_q;
  logic [DATA_W-1:0] quot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (clr) begin
      sum_q <= '0;
    end else if (acc_en) begin
      sum_q <= sum_q + SUM_W'(addend);
    end
  end

  // Division by a power-of-two depth: drop the low SHIFT bits.
  assign quot = sum_q[SUM_W-1:SHIFT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mean_q <= '0;
    end else if (ld_mean) begin
      mean_q <= quot;
    end
  end

  assign mean = mean_q;

  // R5: adding never wraps the accumulator.
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |=> (sum_q >= $past(sum_q)));

  // R9: the result register moves only on the division step.
  p_mean_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_mean |=> $stable(mean_q));
endmodule

// File: rtl/mean_calc.sv
module mean_calc #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  output logic [DATA_W-1:0] mean,
  output logic              done
);
  logic [AW-1:0]     rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic              clr, acc_en, ld_mean, idle;

  initial begin
    p_depth_pow2: assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0);
  end

  assign wr_ready = idle;

  mean_regbank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_valid && idle),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  mean_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .idx     (rd_idx),
    .clr     (clr),
    .acc_en  (acc_en),
    .ld_mean (ld_mean),
    .idle    (idle),
    .done    (done)
  );

  mean_accum #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .acc_en  (acc_en),
    .ld_mean (ld_mean),
    .addend  (rd_data),
    .mean    (mean)
  );

  // R3: the write stream is never open while a result is shown.
  p_ready_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !done);

  // R3: a start accepted in idle closes the write stream on the next edge.
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && start) |=> !wr_ready);
endmodule

// File: tb/mean_calc_tb_top.sv
module mean_calc_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int AW     = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [AW-1:0]     wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] mean;
  logic              done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int mdl [DEPTH];
  int exp_q [$];
  bit counting = 1'b0;
  int edge_cnt = 0;
  bit done_d = 1'b0;

  always #5 clk = ~clk;

  mean_calc #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
    .mean(mean), .done(done)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!counting) edge_cnt <= 0;
    else           edge_cnt <= edge_cnt + 1;
  end

  // Monitor: on each rising done, pop the scoreboard and compare.
  always @(negedge clk) begin
    if (done && !done_d) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected done", 1, 0);
      end else begin
        check("R6 mean", int'(mean), exp_q.pop_front());
        check("R7 latency", edge_cnt, DEPTH + 2);
      end
    end
    done_d = done;
  end

  task automatic write_word(int addr, int data);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = AW'(addr);
    wr_data  = DATA_W'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_bank();
    for (int i = 0; i < DEPTH; i++) write_word(i, mdl[i]);
  endtask

  // Driver: pushes the expected mean, runs one operation, probes the handshake.
  task automatic run_op(bit poke_busy);
    int sum = 0;
    int waited = 0;
    for (int i = 0; i < DEPTH; i++) sum += mdl[i];
    exp_q.push_back(sum >> AW);
    @(negedge clk);
    start = 1'b1;
    counting = 1'b1;
    @(negedge clk);
    check("R3 ready low while busy", int'(wr_ready), 0);
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    check("R7 done reached", int'(done), 1);
    counting = 1'b0;
    for (int h = 0; h < 3; h++) begin
      if (poke_busy && h == 0) begin
        wr_valid = 1'b1;
        wr_addr  = '0;
        wr_data  = 8'hAB;
        check("R3 ready low at done", int'(wr_ready), 0);
      end
      @(negedge clk);
      wr_valid = 1'b0;
      check("R8 done held", int'(done), 1);
    end
    start = 1'b0;
    @(negedge clk);
    check("R8 done dropped", int'(done), 0);
    check("R8 ready back", int'(wr_ready), 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    check("R1 done reset", int'(done), 0);
    check("R1 mean reset", int'(mean), 0);
    check("R1 ready reset", int'(wr_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    // R2, R6: ramp 0..7, sum 28, truncated mean 3.
    for (int i = 0; i < DEPTH; i++) mdl[i] = i;
    load_bank();
    run_op(1'b0);
    check("R9 mean held in idle", int'(mean), 3);

    // R5: all-ones bank must not wrap.
    for (int i = 0; i < DEPTH; i++) mdl[i] = 255;
    load_bank();
    run_op(1'b1);
    // R3: the poked write at done must not reach entry 0; rerun same bank.
    run_op(1'b0);

    // R4: only the top entry is nonzero.
    for (int i = 0; i < DEPTH; i++) mdl[i] = 0;
    mdl[DEPTH-1] = 200;
    load_bank();
    run_op(1'b0);

    // R4: only the bottom entry is nonzero.
    mdl[DEPTH-1] = 0;
    mdl[0] = 201;
    write_word(DEPTH - 1, 0);
    write_word(0, 201);
    run_op(1'b0);

    // R6: mixed pattern with a remainder.
    for (int i = 0; i < DEPTH; i++) mdl[i] = (i * 37 + 5) % 256;
    load_bank();
    run_op(1'b0);

    // R2: a single rewrite changes the next result.
    mdl[3] = 250;
    write_word(3, 250);
    run_op(1'b0);

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule